// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block is the digital front end of a 10-bit voltage-output converter. It listens to a three-wire serial link made of an active-low frame strobe, a serial clock and a data line. It assembles 16-bit command words and turns each complete word into a stored conversion code and a two-bit operating mode. The analog section beside it reads the code, an amplifier enable, a power-down flag and a one-hot output-termination select.

The serial pins are brought into the system clock domain through synchronizer chains. Edges of the serial clock and of the frame strobe are then found by comparing each synchronized level with its delayed copy. A frame starts when the strobe falls. Each falling serial-clock edge shifts one bit in, most significant bit first. The sixteenth edge commits the word. If the strobe rises before that edge, the partial frame is dropped without trace.

Top module: `sdac_cmd_rx`

## Requirements
- R1: After reset the code is 0, the mode is 00 (normal), `amp_en_o` is 1, `pd_o` is 0, `term_o` is 000 and `update_o` is 0.
- R2: While `sync_n_i` is low, each falling edge of `sclk_i` samples `din_i`, most significant bit first. On the sixteenth edge a word whose bits 13:12 are 00 loads bits 9:0 into the code register.
- R3: Word bits 13:12 select the mode: 00 normal, 01 power-down with strong pull-down, 10 power-down with weak pull-down, 11 power-down with open output. `pd_o` is 1 and `amp_en_o` is 0 in every power-down mode. `term_o` is 001, 010 or 100 for modes 01, 10 and 11, and 000 in normal mode.
- R4: Word bits 15:14 have no effect on the code, the mode or any output.
- R5: If `sync_n_i` rises before the sixteenth falling edge, the code, the mode and all outputs keep their values and no update pulse is produced.
- R6: A word that selects a power-down mode updates only the mode. The stored code is kept, so the later normal-mode state shows the same code.
- R7: After the sixteenth edge, further falling edges while `sync_n_i` stays low are ignored. No new frame starts until `sync_n_i` rises and falls again.
- R8: Every committed word produces exactly one `update_o` pulse, one clock cycle wide.
- R9: While `sync_n_i` is high, the bit counter and the shift register are held clear. A frame that follows an aborted one is therefore decoded from its own sixteen bits only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| sync_n_i | input | 1 | Active-low frame strobe |
| din_i | input | 1 | Serial data, most significant bit first |
| code_o | output | 10 | Stored conversion code |
| mode_o | output | 2 | Stored operating mode |
| update_o | output | 1 | One-cycle pulse per committed word |
| pd_o | output | 1 | High in any power-down mode |
| amp_en_o | output | 1 | Output amplifier enable, high in normal mode |
| term_o | output | 3 | One-hot termination: bit 0 strong pull-down, bit 1 weak pull-down, bit 2 open |

## Verification
Directed frames use all-ones and mixed codes with the don't-care bits set. This separates correct field extraction from bit-order or offset errors. Each power-down encoding is written with a different code, to show that the mode changes while the code stays. Frames are aborted after 0, 7 and 15 bits, which separates a correct sixteenth-edge commit from an off-by-one counter and from leftover shift state. Frames with surplus clock edges before the strobe rises expose any re-arming without a new strobe fall. Seeded random words, lengths and surplus edges then mix all of these against a bench model.

// File: rtl/sdac_rx_pkg.sv
package sdac_rx_pkg;

  localparam int MODE_W = 2;
  localparam int TERM_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_RUN     = 2'b00,
    MODE_PD_LOW  = 2'b01,
    MODE_PD_WEAK = 2'b10,
    MODE_PD_OPEN = 2'b11
  } op_mode_e;

  // One-hot termination select for a mode; zero when running.
  function automatic logic [TERM_W-1:0] term_for(input op_mode_e m);
    logic [TERM_W-1:0] t;
    case (m)
      MODE_PD_LOW:  t = 3'b001;
      MODE_PD_WEAK: t = 3'b010;
      MODE_PD_OPEN: t = 3'b100;
      default:      t = '0;
    endcase
    return t;
  endfunction

  function automatic logic is_powered_down(input op_mode_e m);
    return m != MODE_RUN;
  endfunction

endpackage

// File: rtl/sdac_pin_sync.sv
module sdac_pin_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] prev_o
);

  // pipe[0..STAGES-1] synchronize, pipe[STAGES] is the delayed copy for edges
  logic [STAGES:0][N-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= pin_i;
      for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign lvl_o  = pipe[STAGES-1];
  assign prev_o = pipe[STAGES];

endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_lvl_i,
  input  logic              sync_prev_i,
  input  logic              sclk_lvl_i,
  input  logic              sclk_prev_i,
  input  logic              din_lvl_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_stb_o,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic              armed_o,
  output logic              sclk_fall_o,
  output logic              abort_o
);

  logic [WORD_W-1:0] shreg_q;
  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              armed_q;
  logic              stb_q;

  logic sync_fall;
  logic sclk_fall;
  logic take_bit;
  logic last_bit;
  logic [WORD_W-1:0] shreg_nxt;

  assign sync_fall = sync_prev_i & ~sync_lvl_i;
  assign sclk_fall = sclk_prev_i & ~sclk_lvl_i;
  assign take_bit  = armed_q & ~sync_lvl_i & sclk_fall;
  assign last_bit  = take_bit & (cnt_q == CNT_W'(WORD_W - 1));
  assign shreg_nxt = {shreg_q[WORD_W-2:0], din_lvl_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (sync_lvl_i) begin
      // strobe high: idle, everything cleared (also discards partial frames)
      shreg_q <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (sync_fall) armed_q <= 1'b1;
      if (take_bit) begin
        shreg_q <= shreg_nxt;
        cnt_q   <= cnt_q + 1'b1;
      end
      if (last_bit) armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= last_bit;
      if (last_bit) word_q <= shreg_nxt;
    end
  end

  assign word_o      = word_q;
  assign word_stb_o  = stb_q;
  assign bit_cnt_o   = cnt_q;
  assign armed_o     = armed_q;
  assign sclk_fall_o = sclk_fall;
  assign abort_o     = armed_q & sync_lvl_i;

endmodule

// File: rtl/sdac_cmd_regs.sv
module sdac_cmd_regs
  import sdac_rx_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int CODE_W   = 10,
  parameter int MODE_LSB = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic              stb_i,
  output logic [CODE_W-1:0] code_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              update_o,
  output logic              pd_o,
  output logic              amp_en_o,
  output logic [TERM_W-1:0] term_o
);

  function automatic op_mode_e field_mode(input logic [WORD_W-1:0] w);
    return op_mode_e'(w[MODE_LSB +: MODE_W]);
  endfunction

  function automatic logic [CODE_W-1:0] field_code(input logic [WORD_W-1:0] w);
    return w[CODE_W-1:0];
  endfunction

  op_mode_e          mode_q;
  logic [CODE_W-1:0] code_q;
  logic              upd_q;
  op_mode_e          new_mode;

  assign new_mode = field_mode(word_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      code_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= stb_i;
      if (stb_i) begin
        mode_q <= new_mode;
        // power-down words leave the stored code untouched
        if (!is_powered_down(new_mode)) code_q <= field_code(word_i);
      end
    end
  end

  always_comb begin
    pd_o     = is_powered_down(mode_q);
    amp_en_o = ~is_powered_down(mode_q);
    term_o   = term_for(mode_q);
  end

  assign code_o   = code_q;
  assign mode_o   = mode_q;
  assign update_o = upd_q;

endmodule

// File: rtl/sdac_cmd_rx.sv
module sdac_cmd_rx #(
  parameter int WORD_W   = 16,
  parameter int CODE_W   = 10,
  parameter int MODE_LSB = 12,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sync_n_i,
  input  logic              din_i,
  output logic [CODE_W-1:0] code_o,
  output logic [1:0]        mode_o,
  output logic              update_o,
  output logic              pd_o,
  output logic              amp_en_o,
  output logic [2:0]        term_o
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int PIN_N = 3;
  // pin vector order: {sync_n, sclk, din}; strobe and clock idle high
  localparam logic [PIN_N-1:0] PIN_IDLE = 3'b110;

  logic [PIN_N-1:0] pin_lvl;
  logic [PIN_N-1:0] pin_prev;

  logic              sync_lvl;
  logic [WORD_W-1:0] word;
  logic              word_stb;
  logic [CNT_W-1:0]  bit_cnt;
  logic              armed;
  logic              sclk_fall;
  logic              abort_evt;

  sdac_pin_sync #(
    .N       (PIN_N),
    .STAGES  (SYNC_STG),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  ({sync_n_i, sclk_i, din_i}),
    .lvl_o  (pin_lvl),
    .prev_o (pin_prev)
  );

  assign sync_lvl = pin_lvl[2];

  sdac_frame_rx #(
    .WORD_W (WORD_W)
  ) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_lvl_i  (pin_lvl[2]),
    .sync_prev_i (pin_prev[2]),
    .sclk_lvl_i  (pin_lvl[1]),
    .sclk_prev_i (pin_prev[1]),
    .din_lvl_i   (pin_lvl[0]),
    .word_o      (word),
    .word_stb_o  (word_stb),
    .bit_cnt_o   (bit_cnt),
    .armed_o     (armed),
    .sclk_fall_o (sclk_fall),
    .abort_o     (abort_evt)
  );

  sdac_cmd_regs #(
    .WORD_W   (WORD_W),
    .CODE_W   (CODE_W),
    .MODE_LSB (MODE_LSB)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_i   (word),
    .stb_i    (word_stb),
    .code_o   (code_o),
    .mode_o   (mode_o),
    .update_o (update_o),
    .pd_o     (pd_o),
    .amp_en_o (amp_en_o),
    .term_o   (term_o)
  );

endmodule

// File: rtl/sdac_cmd_rx_chk.sv
module sdac_cmd_rx_chk #(
  parameter int WORD_W = 16,
  parameter int CODE_W = 10,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_lvl,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              word_stb,
  input logic              abort_evt,
  input logic [CODE_W-1:0] code_o,
  input logic [1:0]        mode_o,
  input logic              update_o,
  input logic              pd_o,
  input logic              amp_en_o,
  input logic [2:0]        term_o
);

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_W)); // R7

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lvl |=> (bit_cnt == '0)); // R9

  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |=> !update_o); // R8

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !update_o |-> $stable(code_o)); // R5

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !update_o |-> $stable(mode_o)); // R5

  AST_ABORT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !word_stb); // R5

  AST_PD_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (update_o && mode_o != 2'b00) |-> $stable(code_o)); // R6

  AST_TERM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(term_o)); // R3

  AST_AMP_VS_PD: assert property (@(posedge clk) disable iff (!rst_n)
    amp_en_o != pd_o); // R3

endmodule

bind sdac_cmd_rx sdac_cmd_rx_chk #(
  .WORD_W (WORD_W),
  .CODE_W (CODE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sync_lvl  (sync_lvl),
  .bit_cnt   (bit_cnt),
  .word_stb  (word_stb),
  .abort_evt (abort_evt),
  .code_o    (code_o),
  .mode_o    (mode_o),
  .update_o  (update_o),
  .pd_o      (pd_o),
  .amp_en_o  (amp_en_o),
  .term_o    (term_o)
);

// File: tb/sdac_cmd_rx_tb.sv
module sdac_cmd_rx_tb;

  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b1;
  logic       sync_n = 1'b1;
  logic       din = 1'b0;
  logic [9:0] code_o;
  logic [1:0] mode_o;
  logic       update_o;
  logic       pd_o;
  logic       amp_en_o;
  logic [2:0] term_o;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int run_len = 0;
  int max_len = 0;
  bit finished = 0;

  logic [9:0] m_code = '0;
  logic [1:0] m_mode = '0;

  always #2.5 clk = ~clk;

  sdac_cmd_rx u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_i   (sclk),
    .sync_n_i (sync_n),
    .din_i    (din),
    .code_o   (code_o),
    .mode_o   (mode_o),
    .update_o (update_o),
    .pd_o     (pd_o),
    .amp_en_o (amp_en_o),
    .term_o   (term_o)
  );

  // pulse monitor
  always @(negedge clk) begin
    if (update_o) begin
      pulses++;
      run_len++;
      if (run_len > max_len) max_len = run_len;
    end else begin
      run_len = 0;
    end
  end

  function automatic logic [2:0] exp_term(input logic [1:0] m);
    logic [2:0] t;
    t = '0;
    if (m != 2'b00) t[m - 2'd1] = 1'b1;
    return t;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    @(negedge clk);
    din = b;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
  endtask

  // send nbits of w (MSB first), then extra surplus clock edges, then raise strobe
  task automatic frame(input logic [15:0] w, input int nbits, input int extra);
    pulses  = 0;
    max_len = 0;
    @(negedge clk);
    sync_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) put_bit(w[15-i]);
    for (int i = 0; i < extra; i++) put_bit(1'($urandom));
    repeat (HALF) @(negedge clk);
    sync_n = 1'b1;
    repeat (12) @(negedge clk);
    if (nbits == 16) begin
      m_mode = w[13:12];
      if (w[13:12] == 2'b00) m_code = w[9:0];
    end
  endtask

  task automatic check_state(input string req);
    check(req, "code", int'(code_o), int'(m_code));
    check(req, "mode", int'(mode_o), int'(m_mode));
    check(req, "pd", int'(pd_o), int'(m_mode != 2'b00));
    check(req, "amp_en", int'(amp_en_o), int'(m_mode == 2'b00));
    check(req, "term", int'(term_o), int'(exp_term(m_mode)));
  endtask

  task automatic check_pulses(input string req, input int n);
    check(req, "update pulses", pulses, n);
    if (n > 0) check("R8", "update width", max_len, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0c0d));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check_state("R1");
    check("R1", "update", int'(update_o), 0);

    // R2 normal write, all ones code
    frame(16'h03FF, 16, 0);
    check_state("R2"); check_pulses("R2", 1);
    frame(16'h0000 | 10'h2A5, 16, 0);
    check_state("R2"); check_pulses("R2", 1);

    // R4 don't-care bits set
    frame(16'hC155, 16, 0);
    check_state("R4");
    check("R4", "code value", int'(code_o), 'h155);
    check_pulses("R4", 1);

    // R3 / R6 each power-down mode with a different code field
    frame(16'h10AA, 16, 0);
    check_state("R3"); check("R6", "code kept", int'(code_o), 'h155);
    frame(16'h2333, 16, 0);
    check_state("R3"); check("R6", "code kept", int'(code_o), 'h155);
    frame(16'hF3CC, 16, 0);
    check_state("R3"); check("R6", "code kept", int'(code_o), 'h155);
    frame(16'h0155, 16, 0);
    check_state("R6"); check_pulses("R6", 1);

    // R5 aborts at 0, 7 and 15 bits
    frame(16'h1000, 0, 0);  check_state("R5"); check_pulses("R5", 0);
    frame(16'h0001, 7, 0);  check_state("R5"); check_pulses("R5", 0);
    frame(16'h2001, 15, 0); check_state("R5"); check_pulses("R5", 0);

    // R9 full frame right after an abort decodes from its own bits
    frame(16'h03C3, 16, 0);
    check_state("R9"); check("R9", "code value", int'(code_o), 'h3C3);
    check_pulses("R9", 1);

    // R7 surplus edges while strobe stays low
    frame(16'h0081, 16, 20);
    check_state("R7"); check("R7", "code value", int'(code_o), 'h081);
    check_pulses("R7", 1);

    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [15:0] w;
      int nb;
      int ex;
      w  = 16'($urandom);
      nb = ($urandom % 4 == 0) ? int'($urandom % 16) : 16;
      ex = (nb == 16 && $urandom % 3 == 0) ? int'($urandom % 18) : 0;
      frame(w, nb, ex);
      check_state(nb == 16 ? "R2" : "R5");
      check_pulses(nb == 16 ? (ex > 0 ? "R7" : "R8") : "R5", nb == 16 ? 1 : 0);
    end

    finish_run();
  end

endmodule